// File: doc/BRIEF.md
# Dual Registered Bidirectional Bus Transceiver

This block is one 9-bit section of a two-way bus transceiver. It has a storage register for each direction. The A side and the B side each use three separate vectors: an input vector, an output vector and an output-enable vector. No real tristate is used. Each direction has three controls:

- a load strobe, which is one cycle wide and stands for a rising edge of that direction's register clock;
- a select, which chooses the live value of the source bus or the stored value;
- an output enable. The enable toward B is active-high. The enable toward A is active-low.

A register samples its bus as that bus is seen at the pins. If a port is being driven by the block, its register sees the driven value and not the external input. Two cases follow from this:

- A store can pick up data that arrived from the opposite side.
- With both paths transparent and both ports enabled, the two paths would form a combinational ring. The block detects this case, raises an error flag and releases both ports.

A test-mode input replaces all four output and enable values with boundary values supplied from outside. While it is high, both registers hold their contents.

Top module: `dual_reg_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage registers clear to zero. After reset, with both selects high, `a_out` and `b_out` read 0.
- R2: On a rising `clk` edge with `ld_ab` high and `tm_en` low, the A register takes the value seen on the A bus. Without that strobe it keeps its value. `ld_ba` works the same way for the B register and the B bus.
- R3: With `sel_ab` = 0, `b_out` equals the value seen on the A bus in the same cycle. With `sel_ab` = 1, it equals the A register.
- R4: With `sel_ba` = 0, `a_out` equals the value seen on the B bus in the same cycle. With `sel_ba` = 1, it equals the B register.
- R5: Outside test mode and outside the ring case, `b_oe` = `oe_ab` and `a_oe` = NOT `oe_ba_n`.
- R6: A register loads on its strobe whether or not either port is enabled.
- R7: With `oe_ab` = 1, `oe_ba_n` = 0 and both selects at 1, the B register drives A and the A register drives B at the same time.
- R8: The value seen on a bus is the block's own output when that port is enabled, and the external input otherwise. For example, a load strobe on the A side while A is driven transparently from B stores the B data.
- R9: When `oe_ab` = 1, `oe_ba_n` = 0 and both selects are 0, outside test mode, `loop_err` is 1 and both `a_oe` and `b_oe` are 0. In every other case `loop_err` is 0.
- R10: With `tm_en` = 1, `a_out`, `a_oe`, `b_out` and `b_oe` equal `tm_a_out`, `tm_a_oe`, `tm_b_out` and `tm_b_oe`. In that mode `loop_err` is 0 and load strobes have no effect on the registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 9 | External value present on the A bus |
| b_in | input | 9 | External value present on the B bus |
| ld_ab | input | 1 | Store strobe for the A register |
| ld_ba | input | 1 | Store strobe for the B register |
| sel_ab | input | 1 | Source for B outputs: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for A outputs: 0 live B, 1 stored B |
| oe_ab | input | 1 | Enable toward B, active-high |
| oe_ba_n | input | 1 | Enable toward A, active-low |
| tm_en | input | 1 | Test mode: boundary values override the ports |
| tm_a_out | input | 9 | Boundary value for A outputs |
| tm_a_oe | input | 1 | Boundary value for A enable |
| tm_b_out | input | 9 | Boundary value for B outputs |
| tm_b_oe | input | 1 | Boundary value for B enable |
| a_out | output | 9 | Value driven toward the A bus |
| a_oe | output | 1 | A bus drive enable |
| b_out | output | 9 | Value driven toward the B bus |
| b_oe | output | 1 | B bus drive enable |
| loop_err | output | 1 | Both paths transparent and both ports enabled |

## Verification
A register that holds a wrong value stays hidden while its select is 0. It appears on the opposite output in the first cycle that the select is 1, and it then persists on that output until the next load strobe. A wrong bus-resolution choice shows up at once as a mismatch on the output fed from that bus. It also shows up one cycle later through whatever the register captured. The sweep walks every combination of selects, enables, test mode and load strobes over changing data, so each such fault is exposed within a few cycles.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Drive decision for both ports of one section.
    typedef struct packed {
        logic a_drive;   // A port driven by the block
        logic b_drive;   // B port driven by the block
        logic ring;      // both paths transparent and both ports enabled
    } drive_plan_t;

    localparam int unsigned PORT_A = 0;
    localparam int unsigned PORT_B = 1;
    localparam int unsigned N_PORTS = 2;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
    import xcvr_pkg::*;
(
    input  logic        sel_ab,
    input  logic        sel_ba,
    input  logic        oe_ab,
    input  logic        oe_ba_n,
    input  logic        tm_en,
    output drive_plan_t plan
);
    logic want_a;
    logic want_b;

    always_comb begin
        want_a = ~oe_ba_n;
        want_b = oe_ab;
        plan.ring    = ~tm_en & want_a & want_b & ~sel_ab & ~sel_ba;
        plan.a_drive = want_a & ~plan.ring;
        plan.b_drive = want_b & ~plan.ring;
    end
endmodule

// File: rtl/xcvr_resolve.sv
module xcvr_resolve
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 9
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] reg_a,
    input  logic [W-1:0] reg_b,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  drive_plan_t  plan,
    output logic [W-1:0] a_seen,
    output logic [W-1:0] b_seen,
    output logic [W-1:0] a_norm,
    output logic [W-1:0] b_norm
);
    // Bus values ignoring any transparent drive onto that bus.
    logic [W-1:0] a_base;
    logic [W-1:0] b_base;

    always_comb begin
        a_base = (plan.a_drive & sel_ba) ? reg_b : a_in;
        b_base = (plan.b_drive & sel_ab) ? reg_a : b_in;
        // A transparent drive on one side excludes one on the other (ring is suppressed),
        // so the opposite bus is fully resolved by its base value.
        a_seen = (plan.a_drive & ~sel_ba) ? b_base : a_base;
        b_seen = (plan.b_drive & ~sel_ab) ? a_base : b_base;
        a_norm = sel_ba ? reg_b : b_seen;
        b_norm = sel_ab ? reg_a : a_seen;
    end
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } store_t;

    store_t st_d;
    store_t st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.val = d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;
endmodule

// File: rtl/xcvr_boundary.sv
module xcvr_boundary
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 9
) (
    input  logic                      tm_en,
    input  logic [N_PORTS-1:0][W-1:0] norm_out,
    input  logic [N_PORTS-1:0]        norm_oe,
    input  logic [N_PORTS-1:0][W-1:0] tm_out,
    input  logic [N_PORTS-1:0]        tm_oe,
    output logic [N_PORTS-1:0][W-1:0] pin_out,
    output logic [N_PORTS-1:0]        pin_oe
);
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        always_comb begin
            pin_out[p] = tm_en ? tm_out[p] : norm_out[p];
            pin_oe[p]  = tm_en ? tm_oe[p]  : norm_oe[p];
        end
    end
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ld_ab,
    input  logic         ld_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic         tm_en,
    input  logic [W-1:0] tm_a_out,
    input  logic         tm_a_oe,
    input  logic [W-1:0] tm_b_out,
    input  logic         tm_b_oe,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         loop_err
);
    drive_plan_t               plan;
    logic [N_PORTS-1:0][W-1:0] seen;
    logic [N_PORTS-1:0][W-1:0] stored;
    logic [N_PORTS-1:0]        load;
    logic [N_PORTS-1:0][W-1:0] norm_out;
    logic [N_PORTS-1:0]        norm_oe;
    logic [N_PORTS-1:0][W-1:0] tm_out;
    logic [N_PORTS-1:0]        tm_oe;
    logic [N_PORTS-1:0][W-1:0] pin_out;
    logic [N_PORTS-1:0]        pin_oe;

    xcvr_ctrl u_ctrl (
        .sel_ab  (sel_ab),
        .sel_ba  (sel_ba),
        .oe_ab   (oe_ab),
        .oe_ba_n (oe_ba_n),
        .tm_en   (tm_en),
        .plan    (plan)
    );

    xcvr_resolve #(.W(W)) u_resolve (
        .a_in   (a_in),
        .b_in   (b_in),
        .reg_a  (stored[PORT_A]),
        .reg_b  (stored[PORT_B]),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .plan   (plan),
        .a_seen (seen[PORT_A]),
        .b_seen (seen[PORT_B]),
        .a_norm (norm_out[PORT_A]),
        .b_norm (norm_out[PORT_B])
    );

    always_comb begin
        load[PORT_A]    = ld_ab & ~tm_en;
        load[PORT_B]    = ld_ba & ~tm_en;
        norm_oe[PORT_A] = plan.a_drive;
        norm_oe[PORT_B] = plan.b_drive;
        tm_out[PORT_A]  = tm_a_out;
        tm_out[PORT_B]  = tm_b_out;
        tm_oe[PORT_A]   = tm_a_oe;
        tm_oe[PORT_B]   = tm_b_oe;
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_store
        xcvr_store #(.W(W)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load[p]),
            .d     (seen[p]),
            .q     (stored[p])
        );
    end

    xcvr_boundary #(.W(W)) u_boundary (
        .tm_en    (tm_en),
        .norm_out (norm_out),
        .norm_oe  (norm_oe),
        .tm_out   (tm_out),
        .tm_oe    (tm_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    assign a_out    = pin_out[PORT_A];
    assign a_oe     = pin_oe[PORT_A];
    assign b_out    = pin_out[PORT_B];
    assign b_oe     = pin_oe[PORT_B];
    assign loop_err = plan.ring;
endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
    parameter int unsigned W = 9
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ld_ab,
    input logic         ld_ba,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         oe_ab,
    input logic         oe_ba_n,
    input logic         tm_en,
    input logic [W-1:0] tm_a_out,
    input logic         tm_a_oe,
    input logic [W-1:0] tm_b_out,
    input logic         tm_b_oe,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         loop_err
);
    // R5
    enable_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tm_en && !loop_err) |-> (b_oe == oe_ab) && (a_oe == !oe_ba_n));

    // R9
    ring_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_err |-> (!a_oe && !b_oe && !sel_ab && !sel_ba));

    // R10
    boundary_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tm_en |-> (a_out == tm_a_out) && (a_oe == tm_a_oe) &&
                  (b_out == tm_b_out) && (b_oe == tm_b_oe) && !loop_err);

    // R2
    a_store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tm_en && sel_ab && !ld_ab) ##1 (!tm_en && sel_ab) |-> $stable(b_out));

    // R2
    b_store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tm_en && sel_ba && !ld_ba) ##1 (!tm_en && sel_ba) |-> $stable(a_out));
endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_ab    (ld_ab),
    .ld_ba    (ld_ba),
    .sel_ab   (sel_ab),
    .sel_ba   (sel_ba),
    .oe_ab    (oe_ab),
    .oe_ba_n  (oe_ba_n),
    .tm_en    (tm_en),
    .tm_a_out (tm_a_out),
    .tm_a_oe  (tm_a_oe),
    .tm_b_out (tm_b_out),
    .tm_b_oe  (tm_b_oe),
    .a_out    (a_out),
    .a_oe     (a_oe),
    .b_out    (b_out),
    .b_oe     (b_oe),
    .loop_err (loop_err)
);

// File: tb/tb_dual_reg_xcvr.sv
module tb_dual_reg_xcvr;
    localparam int unsigned W     = 9;
    localparam int          CLK_P = 10;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in, tm_a_out, tm_b_out;
    logic         ld_ab, ld_ba, sel_ab, sel_ba, oe_ab, oe_ba_n, tm_en, tm_a_oe, tm_b_oe;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, loop_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] m_a, m_b;   // bench model of the two registers

    always #(CLK_P/2) clk = ~clk;

    dual_reg_xcvr #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ld_ab(ld_ab), .ld_ba(ld_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .tm_en(tm_en),
        .tm_a_out(tm_a_out), .tm_a_oe(tm_a_oe), .tm_b_out(tm_b_out), .tm_b_oe(tm_b_oe),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe), .loop_err(loop_err)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected bus values derived from R8/R9: a driven port shows its own output.
    task automatic expect_now(output logic [W-1:0] ea_bus, output logic [W-1:0] eb_bus,
                              output logic [W-1:0] ea_out, output logic [W-1:0] eb_out,
                              output logic ea_oe, output logic eb_oe, output logic e_ring);
        logic aen, ben;
        aen    = !oe_ba_n;
        ben    = oe_ab;
        e_ring = !tm_en && aen && ben && !sel_ab && !sel_ba;
        if (e_ring) begin aen = 1'b0; ben = 1'b0; end
        if (!aen)        ea_bus = a_in;
        else if (sel_ba) ea_bus = m_b;
        else if (ben)    ea_bus = m_a;     // B bus holds stored A (sel_ab must be 1)
        else             ea_bus = b_in;
        if (!ben)        eb_bus = b_in;
        else if (sel_ab) eb_bus = m_a;
        else if (aen)    eb_bus = m_b;
        else             eb_bus = a_in;
        ea_out = sel_ba ? m_b : eb_bus;
        eb_out = sel_ab ? m_a : ea_bus;
        ea_oe  = aen;
        eb_oe  = ben;
    endtask

    // One cycle: drive at negedge, check, then model the rising edge.
    task automatic step(input logic [W-1:0] ai, input logic [W-1:0] bi,
                        input logic lab, input logic lba, input logic sab, input logic sba,
                        input logic oab, input logic obn, input logic tm,
                        input logic [W-1:0] ta, input logic toa, input logic [W-1:0] tb, input logic tob);
        logic [W-1:0] eab, ebb, eao, ebo;
        logic eaoe, eboe, er;
        @(negedge clk);
        a_in = ai; b_in = bi; ld_ab = lab; ld_ba = lba; sel_ab = sab; sel_ba = sba;
        oe_ab = oab; oe_ba_n = obn; tm_en = tm;
        tm_a_out = ta; tm_a_oe = toa; tm_b_out = tb; tm_b_oe = tob;
        #2;
        expect_now(eab, ebb, eao, ebo, eaoe, eboe, er);
        if (tm) begin
            check("R10 a_out", a_out, ta);
            check("R10 a_oe", W'(a_oe), W'(toa));
            check("R10 b_out", b_out, tb);
            check("R10 b_oe", W'(b_oe), W'(tob));
            check("R10 loop_err", W'(loop_err), '0);
        end else begin
            check(sba ? "R4 a_out stored" : "R4 a_out live", a_out, eao);
            check(sab ? "R3 b_out stored" : "R3 b_out live", b_out, ebo);
            check(er ? "R9 a_oe" : "R5 a_oe", W'(a_oe), W'(eaoe));
            check(er ? "R9 b_oe" : "R5 b_oe", W'(b_oe), W'(eboe));
            check("R9 loop_err", W'(loop_err), W'(er));
        end
        @(posedge clk);
        if (!tm) begin
            if (lab) m_a = eab;
            if (lba) m_b = ebb;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        a_in = '0; b_in = '0; ld_ab = 1'b1; ld_ba = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        oe_ab = 1'b1; oe_ba_n = 1'b0; tm_en = 1'b0;
        tm_a_out = '0; tm_a_oe = 1'b0; tm_b_out = '0; tm_b_oe = 1'b0;
        a_in = 9'h1FF; b_in = 9'h1FF;
        m_a = '0; m_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ld_ab = 1'b0; ld_ba = 1'b0;
        #2;
        // R1: registers cleared, both stored paths show zero
        check("R1 a_out after reset", a_out, '0);
        check("R1 b_out after reset", b_out, '0);

        // R6: loads with both ports disabled
        step(9'h155, 9'h0AA, 1, 1, 1, 1, 0, 1, 0, '0, 0, '0, 0);
        // R7: both stored paths driving at once
        step(9'h000, 9'h000, 0, 0, 1, 1, 1, 0, 0, '0, 0, '0, 0);
        check("R6 stored A while disabled", b_out, 9'h155);
        check("R7 stored B onto A", a_out, 9'h0AA);
        // R8: A driven transparently from B; A strobe stores B data
        step(9'h03C, 9'h1C3, 1, 0, 0, 0, 0, 0, 0, '0, 0, '0, 0);
        step(9'h000, 9'h000, 0, 0, 1, 1, 0, 1, 0, '0, 0, '0, 0);
        check("R8 A register took B data", b_out, 9'h1C3);
        // R10: strobes in test mode leave registers untouched
        step(9'h0F0, 9'h00F, 1, 1, 1, 1, 1, 0, 1, 9'h111, 1, 9'h022, 0);
        step(9'h000, 9'h000, 0, 0, 1, 1, 1, 0, 0, '0, 0, '0, 0);
        check("R10 A register held in test mode", b_out, 9'h1C3);
        check("R10 B register held in test mode", a_out, 9'h0AA);
        // R2: strobe captures, no strobe holds
        step(9'h0AB, 9'h154, 1, 1, 0, 0, 0, 1, 0, '0, 0, '0, 0);
        step(9'h1FF, 9'h1FF, 0, 0, 1, 1, 0, 1, 0, '0, 0, '0, 0);
        check("R2 A register captured", b_out, 9'h0AB);
        check("R2 B register captured", a_out, 9'h154);

        // Sweep over all controls, strobes and test mode with varying data
        for (int i = 0; i < 1024; i++) begin
            logic [9:0] c;
            c = 10'(i);
            step(W'((i * 37 + 5)) & MASK, W'((i * 91 + 200)) & MASK,
                 c[5], c[6], c[0], c[1], c[2], c[3], c[4] & c[7],
                 W'((i * 13 + 3)) & MASK, c[8], W'((i * 29 + 7)) & MASK, c[9]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule